// File: doc/BRIEF.md
# I2C Single-Master Byte Controller

This block runs the byte-level side of an I2C master. It steps through start, address, data, acknowledge and stop phases, one bus bit per state step. A separate timing generator supplies the SCL level and two one-cycle strobes, one at the middle of the SCL low phase and one at the middle of the high phase. State changes happen only on the low-phase strobe. SDA is sampled, and start and stop edges are made, only on the high-phase strobe.

The user holds the enable high with a 7-bit target address, a direction bit and a write byte. The controller then runs a transaction. Busy falls during each acknowledge slot that follows a data byte. While busy is low, the user picks the next action:
- another write byte;
- another read byte;
- a repeated start to a new address;
- a stop.

A missing slave acknowledge raises a sticky error flag.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, busy and the error flag are 0 and both SDA and SCL are released (read high through the pull-ups).
- R2: With enable high in idle, the controller latches its inputs and issues a start condition. The first byte on the bus is the address in bits 7..1 with the direction bit in bit 0 (1 = read), sent MSB first.
- R3: SDA changes only while SCL is low, except at the high-phase strobe. There it falls to make a start and rises to make a stop, and every transaction ends with exactly one stop.
- R4: In a write, each data byte goes out MSB first after the address acknowledge, followed by a released SDA slot for the slave acknowledge.
- R5: In a read, the byte sampled MSB first from SDA is on the read-data output when busy falls at the master-acknowledge slot.
- R6: The master drives its acknowledge slot low (ACK) only if enable and direction are both high at the strobe that ends the byte's last bit. Otherwise it releases the slot (NACK).
- R7: A high SDA level at a slave acknowledge slot sets the error flag. The flag stays set until enable is seen high in idle.
- R8: Busy is low in idle, in the slave acknowledge after a data byte and in the master acknowledge. It is high in every other state.
- R9: In the slave acknowledge after a data byte, enable high with direction low sends a further byte with freshly latched write data, and enable low leads to a stop.
- R10: A repeated start with a newly latched address word occurs without a stop in two cases: from the slave acknowledge after a data byte when enable and direction are high, and from the master acknowledge when enable is high and direction is low.
- R11: The state advances only on the low-phase strobe. With strobes absent, a raised enable leaves the controller idle.
- R12: SCL follows the supplied clock level while a transaction runs and is released in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_level | input | 1 | SCL level from the timing generator |
| low_mid | input | 1 | One-cycle strobe at the middle of SCL low |
| high_mid | input | 1 | One-cycle strobe at the middle of SCL high |
| en | input | 1 | Command enable |
| slave_addr | input | 7 | Target address |
| rd_nwr | input | 1 | Direction, 1 = read |
| wdata | input | 8 | Byte to write |
| rdata | output | 8 | Last byte read |
| busy | output | 1 | Transaction in a non-handshake state |
| ack_err | output | 1 | Sticky missing-acknowledge flag |
| sda | inout | 1 | Open-drain serial data |
| scl | inout | 1 | Serial clock |

## Verification
The hardest situations to reach are the two repeated-start paths. In each, the user must change enable and direction during one acknowledge slot: in the master-acknowledge case before the read byte even ends. The stimulus reaches them with a small slave model on the bus and mixed transactions. Random address, data, byte counts and kinds are drawn from a seeded generator, and the command inputs are set on busy edges. The slave logs every byte, every master acknowledge and every start and stop. A separate directed sequence refuses the address to reach the sticky error flag, and suppresses the strobes to hold enable high in idle.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_level,
  input  logic       low_mid,
  input  logic       high_mid,
  input  logic       en,
  input  logic [6:0] slave_addr,
  input  logic       rd_nwr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy,
  output logic       ack_err,
  inout  wire        sda,
  inout  wire        scl
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_ACK1, S_WRITE, S_READ, S_ACK2, S_MACK, S_STOP
  } st_t;

  st_t        st;
  logic       sda_o;
  logic [2:0] bit_cnt;
  logic [7:0] word, tx, rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sda_o   <= 1'b1;
      bit_cnt <= 3'd7;
      ack_err <= 1'b0;
      word    <= '0;
      tx      <= '0;
      rx      <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          sda_o   <= 1'b1;
          bit_cnt <= 3'd7;
          if (en) begin
            ack_err <= 1'b0;
            word    <= {slave_addr, rd_nwr};
            tx      <= wdata;
            if (low_mid) st <= S_START;
          end
        end
        S_START: begin
          if (high_mid) sda_o <= 1'b0;
          if (low_mid) begin
            st      <= S_ADDR;
            sda_o   <= word[7];
            bit_cnt <= 3'd7;
          end
        end
        S_ADDR: if (low_mid) begin
          if (bit_cnt == 3'd0) begin
            st    <= S_ACK1;
            sda_o <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt - 3'd1;
            sda_o   <= word[bit_cnt - 3'd1];
          end
        end
        S_ACK1: begin
          if (high_mid && sda) ack_err <= 1'b1;
          if (low_mid) begin
            bit_cnt <= 3'd7;
            if (word[0]) begin
              st    <= S_READ;
              sda_o <= 1'b1;
            end else begin
              st    <= S_WRITE;
              sda_o <= tx[7];
            end
          end
        end
        S_WRITE: if (low_mid) begin
          if (bit_cnt == 3'd0) begin
            st      <= S_ACK2;
            sda_o   <= 1'b1;
            bit_cnt <= 3'd7;
          end else begin
            bit_cnt <= bit_cnt - 3'd1;
            sda_o   <= tx[bit_cnt - 3'd1];
          end
        end
        S_READ: begin
          if (high_mid) rx[bit_cnt] <= sda;
          if (low_mid) begin
            if (bit_cnt == 3'd0) begin
              st      <= S_MACK;
              sda_o   <= !(en && rd_nwr);
              bit_cnt <= 3'd7;
            end else begin
              bit_cnt <= bit_cnt - 3'd1;
            end
          end
        end
        S_ACK2: begin
          if (high_mid && sda) ack_err <= 1'b1;
          if (low_mid) begin
            if (en && !rd_nwr) begin
              tx    <= wdata;
              st    <= S_WRITE;
              sda_o <= wdata[7];
            end else if (en) begin
              word  <= {slave_addr, rd_nwr};
              tx    <= wdata;
              st    <= S_START;
              sda_o <= 1'b1;
            end else begin
              st    <= S_STOP;
              sda_o <= 1'b0;
            end
          end
        end
        S_MACK: if (low_mid) begin
          if (en && rd_nwr) begin
            st    <= S_READ;
            sda_o <= 1'b1;
          end else if (en) begin
            word  <= {slave_addr, rd_nwr};
            tx    <= wdata;
            st    <= S_START;
            sda_o <= 1'b1;
          end else begin
            st    <= S_STOP;
            sda_o <= 1'b0;
          end
        end
        S_STOP: begin
          if (high_mid) sda_o <= 1'b1;
          if (low_mid) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = !(st == S_IDLE || st == S_ACK2 || st == S_MACK);
  assign rdata = rx;
  assign scl   = (st != S_IDLE) ? scl_level : 1'bz;
  assign sda   = sda_o ? 1'bz : 1'b0;

  // R11
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_mid |=> $stable(st));

  // R3
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_level && !high_mid) |=> $stable(sda_o));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_err && !(st == S_IDLE && en)) |=> ack_err);

  // R7
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_err && !((st == S_ACK1 || st == S_ACK2) && high_mid)) |=> !ack_err);

  // R5
  read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && low_mid && bit_cnt == 3'd0) |=> (st == S_MACK && !busy));

endmodule

// File: tb/i2c_byte_master_tb.sv
`timescale 1ns/1ps
module i2c_byte_master_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, en = 1'b0, rnw = 1'b0;
  logic [6:0] addr_in = '0;
  logic [7:0] wdata_in = '0;
  wire  [7:0] rdata;
  wire        busy, ack_err;
  wire        sda, scl;
  pullup (sda);
  pullup (scl);

  logic [2:0] ph = '0;
  logic       strobe_on = 1'b1;
  always @(posedge clk) ph <= ph + 3'd1;
  wire scl_level = ph[2];
  wire low_mid   = strobe_on && (ph == 3'd2);
  wire high_mid  = strobe_on && (ph == 3'd6);

  i2c_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .scl_level(scl_level), .low_mid(low_mid),
    .high_mid(high_mid), .en(en), .slave_addr(addr_in), .rd_nwr(rnw),
    .wdata(wdata_in), .rdata(rdata), .busy(busy), .ack_err(ack_err),
    .sda(sda), .scl(scl));

  // slave model
  logic       s_low = 1'b0;
  assign sda = s_low ? 1'b0 : 1'bz;
  logic       p_scl = 1'b1, p_sda = 1'b1, active = 1'b0, dir = 1'b0, rd_nack = 1'b0;
  int         bitn = 0, frame = 0;
  logic [7:0] shift = '0;
  logic [7:0] wlog [0:255];
  logic [7:0] rsup [0:255];
  bit         mlog [0:255];
  int         wcnt = 0, ridx = 0, mcnt = 0, starts = 0, stops = 0, busy_bad = 0;
  bit         nack_addr = 1'b0;

  always @(posedge clk) begin
    logic cs, ds;
    cs = (scl !== 1'b0);
    ds = (sda !== 1'b0);
    if (p_scl && cs && p_sda && !ds) begin
      starts++; active = 1'b1; bitn = 0; frame = 0; s_low <= 1'b0;
    end else if (p_scl && cs && !p_sda && ds) begin
      stops++; active = 1'b0; s_low <= 1'b0;
    end else if (active && !p_scl && cs) begin
      if (bitn < 8) begin
        shift = {shift[6:0], ds}; bitn++;
      end else if (bitn == 8) begin
        bitn = 9;
        if (frame == 2) begin mlog[mcnt] = !ds; mcnt++; rd_nack = ds; end
        if (frame != 3 && busy !== (frame == 0)) busy_bad++;
      end
    end else if (active && p_scl && !cs) begin
      if (bitn == 8) begin
        if (frame == 0) begin
          dir = shift[0]; wlog[wcnt] = shift; wcnt++; s_low <= !nack_addr;
        end else if (frame == 1) begin
          wlog[wcnt] = shift; wcnt++; s_low <= 1'b1;
        end else begin
          s_low <= 1'b0;
          if (frame == 2) ridx++;
        end
      end else if (bitn == 9) begin
        bitn = 0;
        if (frame == 0) frame = nack_addr ? 3 : (dir ? 2 : 1);
        else if (frame == 2 && rd_nack) frame = 3;
        s_low <= (frame == 2) ? !rsup[ridx][7] : 1'b0;
      end else if (frame == 2 && bitn >= 1 && bitn <= 7) begin
        s_low <= !rsup[ridx][7 - bitn];
      end
    end
    p_scl = cs; p_sda = ds;
  end

  int  tests = 0, fails = 0;
  bit  done = 1'b0;
  logic [7:0] tx_b [0:7];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_busy(input logic v);
    while (busy !== v) @(negedge clk);
  endtask

  task automatic begin_cmd(input logic [6:0] a, input logic r, input logic [7:0] d);
    @(negedge clk);
    addr_in = a; rnw = r; wdata_in = d; en = 1'b1;
    wait_busy(1'b1);
  endtask

  task automatic write_phase(input int n);
    for (int i = 0; i < n; i++) begin
      wait_busy(1'b0);
      if (i < n - 1) begin
        wdata_in = tx_b[i + 1]; en = 1'b1; rnw = 1'b0;   // R9 chained byte
        wait_busy(1'b1);
      end
    end
  endtask

  task automatic read_phase(input int n, input logic last_en, input logic last_rnw, input int base);
    for (int i = 0; i < n; i++) begin
      en  = (i < n - 1) ? 1'b1 : last_en;
      rnw = (i < n - 1) ? 1'b1 : last_rnw;
      wait_busy(1'b0);
      chk(rdata == rsup[base + i], "R5 read byte", rdata, rsup[base + i]);
      if (i < n - 1) wait_busy(1'b1);
    end
  endtask

  task automatic stop_seq();
    en = 1'b0;
    wait_busy(1'b1);
    wait_busy(1'b0);
  endtask

  // kind: 0 write, 1 read, 2 write then restart read, 3 read then restart write
  task automatic run_txn(input int kind, input logic [6:0] a, input int nw, input int nr);
    int wb = wcnt, mb = mcnt, sb = starts, pb = stops, rb = ridx, k = 0;
    logic [7:0] exp [0:15];
    for (int i = 0; i < 8; i++) tx_b[i] = 8'($urandom);
    for (int i = 0; i < nr; i++) rsup[rb + i] = 8'($urandom);
    if (kind == 0 || kind == 2) begin
      exp[k++] = {a, 1'b0};
      for (int i = 0; i < nw; i++) exp[k++] = tx_b[i];
      begin_cmd(a, 1'b0, tx_b[0]);
      write_phase(nw);
      if (kind == 2) begin
        exp[k++] = {a, 1'b1};
        en = 1'b1; rnw = 1'b1;                            // R10 restart after write ack
        wait_busy(1'b1);
        read_phase(nr, 1'b0, 1'b1, rb);
      end
      stop_seq();
    end else begin
      exp[k++] = {a, 1'b1};
      begin_cmd(a, 1'b1, 8'h00);
      if (kind == 3) begin
        exp[k++] = {a, 1'b0};
        for (int i = 0; i < nw; i++) exp[k++] = tx_b[i];
        wdata_in = tx_b[0];
        read_phase(nr, 1'b1, 1'b0, rb);                   // R10 restart from master ack
        wait_busy(1'b1);
        write_phase(nw);
      end else begin
        read_phase(nr, 1'b0, 1'b1, rb);
      end
      stop_seq();
    end
    repeat (4) @(negedge clk);
    chk(wcnt - wb == k, "R2/R4 byte count", wcnt - wb, k);
    for (int i = 0; i < k && i < wcnt - wb; i++)
      chk(wlog[wb + i] == exp[i], (i == 0) ? "R2 address word" : "R4/R9 bus byte", wlog[wb + i], exp[i]);
    chk(starts - sb == ((kind >= 2) ? 2 : 1), "R10 start count", starts - sb, (kind >= 2) ? 2 : 1);
    chk(stops - pb == 1, "R3 stop count", stops - pb, 1);
    if (kind != 0) begin
      chk(mcnt - mb == nr, "R6 master ack count", mcnt - mb, nr);
      for (int i = 0; i < nr; i++)
        chk(mlog[mb + i] == (i < nr - 1), "R6 master ack level", mlog[mb + i], (i < nr - 1));
    end
    chk(ack_err == 1'b0, "R7 no error on acked txn", ack_err, 0);
    chk(scl === 1'b1, "R12 scl released in idle", scl, 1);
  endtask

  initial begin
    void'($urandom(32'd7411));
    repeat (5) @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(ack_err === 1'b0, "R1 error after reset", ack_err, 0);
    chk(sda === 1'b1, "R1 sda released", sda, 1);
    chk(scl === 1'b1, "R1 scl released", scl, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed
    run_txn(0, 7'h48, 3, 0);
    run_txn(1, 7'h48, 0, 2);
    run_txn(2, 7'h7F, 1, 2);
    run_txn(3, 7'h00, 2, 1);
    run_txn(1, 7'h2A, 0, 1);

    // R11: no strobes, enable held high, controller stays idle
    strobe_on = 1'b0;
    @(negedge clk);
    addr_in = 7'h11; rnw = 1'b0; en = 1'b1;
    repeat (40) @(negedge clk);
    chk(busy === 1'b0, "R11 no advance without strobe", busy, 0);
    chk(scl === 1'b1, "R12 scl still released", scl, 1);
    en = 1'b0;
    @(negedge clk);
    strobe_on = 1'b1;

    // R7: refused address sets sticky error
    nack_addr = 1'b1;
    for (int i = 0; i < 8; i++) tx_b[i] = 8'hA5;
    begin_cmd(7'h33, 1'b0, 8'hA5);
    write_phase(1);
    stop_seq();
    nack_addr = 1'b0;
    repeat (20) @(negedge clk);
    chk(ack_err === 1'b1, "R7 error held in idle", ack_err, 1);
    strobe_on = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(ack_err === 1'b0, "R7 error cleared by enable", ack_err, 1'b0);
    chk(busy === 1'b0, "R11 idle kept", busy, 0);
    en = 1'b0;
    @(negedge clk);
    strobe_on = 1'b1;

    // random mix
    for (int t = 0; t < 10; t++) begin
      int kind, nw, nr;
      kind = int'($urandom % 4);
      nw   = 1 + int'($urandom % 3);
      nr   = 1 + int'($urandom % 3);
      run_txn(kind, 7'($urandom), (kind == 1) ? 0 : nw, (kind == 0) ? 0 : nr);
    end

    chk(busy_bad == 0, "R8 busy level at ack slots", busy_bad, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule